// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block holds the software-visible state of a four-channel DMA controller. The state comes in through a narrow byte-wide I/O port. Each channel has a 16-bit transfer address and a 16-bit transfer count. Both sit behind one 8-bit port, and one shared byte-pointer flip-flop picks which half a given access touches. A software driver loads the count with the transfer length minus one. It sets a direction and an operating mode through the mode register, loads an 8-bit page value that supplies the upper address bits, and then unmasks the channel.

A small transfer engine consumes a strobe. On each accepted strobe it steps the selected channel's current address up by one and its current count down by one. When the count wraps below zero the channel hits terminal count. An autoinitialize channel then reloads from its base copies and keeps running. Any other channel masks itself. A status byte reports terminal-count events and clears itself when read.

A parameter selects the word-wide variant. In that variant the registers sit on even ports, and the 16-bit counter addresses words, so it reaches twice the byte range.

Top module: `dmarf_regfile`

## Requirements
- R1: After reset every channel is masked (`ch_masked` all ones), the byte pointer selects the low byte, and the status byte reads 0x00.
- R2: Register index 2c reaches channel c's address and index 2c+1 its count. The byte pointer sends the first access to the low byte. Every read or write of an address or count register toggles the pointer.
- R3: Any write to register index 12 returns the byte pointer to the low byte, whatever the data value.
- R4: A write to an address or count byte updates both the base and the current copy. A read returns the current copy live, so clearing the pointer and reading again shows a count that moved between samples.
- R5: A write to index 10 selects a channel with data bits 1:0. Data bit 2 = 1 masks that channel and bit 2 = 0 unmasks it.
- R6: A write to index 11 selects a channel with data bits 1:0. It stores the direction from bits 3:2 (01 = write to memory, 10 = read from memory), the autoinitialize enable from bit 4, and the operation from bits 7:6 (01 single, 11 cascade). `xfer_dir` shows the direction of the channel on `xfer_ch`.
- R7: A strobe on an unmasked, non-cascade channel raises its current address by one and lowers its current count by one. A strobe on a masked or cascade channel changes nothing.
- R8: A strobe that finds the count at 0 is terminal count. The count then reads 0xFFFF and, without autoinitialize, the channel becomes masked.
- R9: With autoinitialize, terminal count reloads the current address and count from the base copies and the channel stays unmasked.
- R10: A read of index 8 returns terminal-count flags in bits 3:0 (bit c = channel c), and that read clears them.
- R11: `xfer_addr` is the page byte above the 16-bit current address. The address wraps within 16 bits and the page never changes.
- R12: With WORD_MODE = 1, register index k sits at port 2k and odd ports are ignored. `xfer_addr` is {page bits 7:1, current address, 0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4+WORD_MODE | Register port number |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle of the read |
| pg_wr | input | 1 | Page register write strobe |
| pg_ch | input | 2 | Channel of the page write |
| pg_wdata | input | PAGE_W | Page value |
| xfer_stb | input | 1 | Transfer strobe |
| xfer_ch | input | 2 | Channel of the strobe and of the transfer outputs |
| xfer_addr | output | PAGE_W+16 | Memory address of the channel on xfer_ch |
| xfer_dir | output | 2 | Direction field of the channel on xfer_ch |
| ch_masked | output | NUM_CH | Per-channel mask state |

## Verification
The bench builds two copies of the block. The first has four channels in byte mode, which covers every channel slot, the autoinitialize and cascade paths, and the address wrap at the 64 KiB edge. The second has two channels with WORD_MODE = 1. It exercises the even-port decode, the rejection of odd ports, the shifted address on the transfer outputs, and the tie-off of the absent channel slots.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;
   localparam int REG_W       = 16;
   localparam int IDX_STATUS  = 8;
   localparam int IDX_MASK    = 10;
   localparam int IDX_MODE    = 11;
   localparam int IDX_CLRPTR  = 12;
   localparam int CH_SLOTS    = 4;

   typedef enum logic [1:0] {
      OP_DEMAND  = 2'b00,
      OP_SINGLE  = 2'b01,
      OP_BLOCK   = 2'b10,
      OP_CASCADE = 2'b11
   } ch_op_e;

   typedef struct packed {
      ch_op_e     op;     // data bits 7:6
      logic       rsvd;   // data bit 5
      logic       autoi;  // data bit 4
      logic [1:0] dir;    // data bits 3:2
   } ch_mode_t;
endpackage

// File: rtl/dmarf_byteptr.sv
module dmarf_byteptr (
   input  logic clk,
   input  logic rst_n,
   input  logic access,
   input  logic clear,
   output logic hi_sel
);
   always_ff @(posedge clk) begin
      if (!rst_n)      hi_sel <= 1'b0;
      else if (clear)  hi_sel <= 1'b0;
      else if (access) hi_sel <= ~hi_sel;
   end

   a_r3_clear_to_low: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !hi_sel);
   a_r2_access_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !clear) |=> (hi_sel != $past(hi_sel)));
endmodule

// File: rtl/dmarf_channel.sv
module dmarf_channel
   import dmarf_pkg::*;
#(
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr,
   input  logic              wr_cnt,
   input  logic              hi_sel,
   input  logic [7:0]        wdata,
   input  logic              mode_wr,
   input  logic              mask_wr,
   input  logic              mask_val,
   input  logic              page_wr,
   input  logic [PAGE_W-1:0] page_data,
   input  logic              step,
   output logic [REG_W-1:0]  cur_addr,
   output logic [REG_W-1:0]  cur_cnt,
   output logic [PAGE_W-1:0] page,
   output ch_mode_t          mode,
   output logic              masked,
   output logic              tc_hit
);
   logic [REG_W-1:0] base_addr, base_cnt;
   logic             run;

   assign run    = step && !masked && (mode.op != OP_CASCADE);
   assign tc_hit = run && (cur_cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_addr <= '0;
         base_cnt  <= '0;
         cur_addr  <= '0;
         cur_cnt   <= '0;
         page      <= '0;
         mode      <= '0;
         masked    <= 1'b1;
      end else begin
         if (run) begin
            if (tc_hit && mode.autoi) begin
               cur_addr <= base_addr;
               cur_cnt  <= base_cnt;
            end else begin
               cur_addr <= cur_addr + 1'b1;
               cur_cnt  <= cur_cnt - 1'b1;
            end
            if (tc_hit && !mode.autoi) masked <= 1'b1;
         end
         if (wr_addr) begin
            if (hi_sel) begin
               base_addr[15:8] <= wdata;
               cur_addr[15:8]  <= wdata;
            end else begin
               base_addr[7:0]  <= wdata;
               cur_addr[7:0]   <= wdata;
            end
         end
         if (wr_cnt) begin
            if (hi_sel) begin
               base_cnt[15:8] <= wdata;
               cur_cnt[15:8]  <= wdata;
            end else begin
               base_cnt[7:0]  <= wdata;
               cur_cnt[7:0]   <= wdata;
            end
         end
         if (mode_wr) mode   <= ch_mode_t'(wdata[7:2]);
         if (mask_wr) masked <= mask_val;
         if (page_wr) page   <= page_data;
      end
   end

   a_r7_blocked_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ((masked || mode.op == OP_CASCADE) && !wr_addr && !wr_cnt)
      |=> ($stable(cur_cnt) && $stable(cur_addr)));
   a_r8_tc_masks: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !masked && mode.op != OP_CASCADE && cur_cnt == '0 && !mode.autoi
       && !mask_wr && !wr_cnt) |=> (masked && cur_cnt == 16'hFFFF));
   a_r9_auto_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !masked && mode.op != OP_CASCADE && cur_cnt == '0 && mode.autoi
       && !mask_wr && !wr_cnt) |=> (!masked && cur_cnt == $past(base_cnt)));
   a_r11_page_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !page_wr |=> $stable(page));
endmodule

// File: rtl/dmarf_regfile.sv
module dmarf_regfile
   import dmarf_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int WORD_MODE = 0,
   parameter int PAGE_W    = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [3+WORD_MODE:0]    io_addr,
   input  logic                    io_wr,
   input  logic                    io_rd,
   input  logic [7:0]              io_wdata,
   output logic [7:0]              io_rdata,
   input  logic                    pg_wr,
   input  logic [1:0]              pg_ch,
   input  logic [PAGE_W-1:0]       pg_wdata,
   input  logic                    xfer_stb,
   input  logic [1:0]              xfer_ch,
   output logic [PAGE_W+REG_W-1:0] xfer_addr,
   output logic [1:0]              xfer_dir,
   output logic [NUM_CH-1:0]       ch_masked
);
   if (NUM_CH < 1 || NUM_CH > CH_SLOTS) begin : g_bad_ch
      $error("NUM_CH must lie in 1..4");
   end
   if (WORD_MODE != 0 && WORD_MODE != 1) begin : g_bad_wm
      $error("WORD_MODE must be 0 or 1");
   end
   if (PAGE_W < 2) begin : g_bad_pg
      $error("PAGE_W must be at least 2");
   end

   logic [3:0] reg_idx;
   logic       port_ok, is_chan, is_cnt, hi_sel, ptr_acc, ptr_clr, stat_rd;
   logic [1:0] ch_of;

   if (WORD_MODE != 0) begin : g_word_dec
      assign reg_idx = io_addr[4:1];
      assign port_ok = !io_addr[0];
   end else begin : g_byte_dec
      assign reg_idx = io_addr[3:0];
      assign port_ok = 1'b1;
   end

   assign is_chan = port_ok && !reg_idx[3];
   assign ch_of   = reg_idx[2:1];
   assign is_cnt  = reg_idx[0];
   assign ptr_acc = (io_wr || io_rd) && is_chan && (int'(ch_of) < NUM_CH);
   assign ptr_clr = io_wr && port_ok && (reg_idx == 4'(IDX_CLRPTR));
   assign stat_rd = io_rd && port_ok && (reg_idx == 4'(IDX_STATUS));

   dmarf_byteptr u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .access (ptr_acc),
      .clear  (ptr_clr),
      .hi_sel (hi_sel)
   );

   logic [REG_W-1:0]  cur_addr_a [CH_SLOTS];
   logic [REG_W-1:0]  cur_cnt_a  [CH_SLOTS];
   logic [PAGE_W-1:0] page_a     [CH_SLOTS];
   ch_mode_t          mode_a     [CH_SLOTS];
   logic [CH_SLOTS-1:0] masked_a, tc_hit_a;

   for (genvar g = 0; g < CH_SLOTS; g++) begin : g_ch
      if (g < NUM_CH) begin : g_live
         dmarf_channel #(.PAGE_W(PAGE_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_addr   (io_wr && is_chan && ch_of == 2'(g) && !is_cnt),
            .wr_cnt    (io_wr && is_chan && ch_of == 2'(g) && is_cnt),
            .hi_sel    (hi_sel),
            .wdata     (io_wdata),
            .mode_wr   (io_wr && port_ok && reg_idx == 4'(IDX_MODE) && io_wdata[1:0] == 2'(g)),
            .mask_wr   (io_wr && port_ok && reg_idx == 4'(IDX_MASK) && io_wdata[1:0] == 2'(g)),
            .mask_val  (io_wdata[2]),
            .page_wr   (pg_wr && pg_ch == 2'(g)),
            .page_data (pg_wdata),
            .step      (xfer_stb && xfer_ch == 2'(g)),
            .cur_addr  (cur_addr_a[g]),
            .cur_cnt   (cur_cnt_a[g]),
            .page      (page_a[g]),
            .mode      (mode_a[g]),
            .masked    (masked_a[g]),
            .tc_hit    (tc_hit_a[g])
         );
      end else begin : g_absent
         assign cur_addr_a[g] = '0;
         assign cur_cnt_a[g]  = '0;
         assign page_a[g]     = '0;
         assign mode_a[g]     = '0;
         assign masked_a[g]   = 1'b1;
         assign tc_hit_a[g]   = 1'b0;
      end
   end

   assign ch_masked = masked_a[NUM_CH-1:0];

   logic [CH_SLOTS-1:0] tc_q;
   always_ff @(posedge clk) begin
      if (!rst_n) tc_q <= '0;
      else        tc_q <= (stat_rd ? '0 : tc_q) | tc_hit_a;
   end

   logic [REG_W-1:0] rd_word;
   always_comb begin
      rd_word  = is_cnt ? cur_cnt_a[ch_of] : cur_addr_a[ch_of];
      io_rdata = '0;
      if (is_chan)  io_rdata = hi_sel ? rd_word[15:8] : rd_word[7:0];
      else if (stat_rd) io_rdata = {4'b0, tc_q};
   end

   if (WORD_MODE != 0) begin : g_word_out
      assign xfer_addr = {page_a[xfer_ch][PAGE_W-1:1], cur_addr_a[xfer_ch], 1'b0};
   end else begin : g_byte_out
      assign xfer_addr = {page_a[xfer_ch], cur_addr_a[xfer_ch]};
   end
   assign xfer_dir = mode_a[xfer_ch].dir;

   a_r10_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && tc_hit_a == '0) |=> (tc_q == '0));
   a_r10_tc_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_hit_a != '0) |=> ((tc_q & $past(tc_hit_a)) == $past(tc_hit_a)));
endmodule

// File: tb/dmarf_regfile_tb_top.sv
module dmarf_regfile_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int total = 0;
   int bad   = 0;

   // byte-mode instance
   logic [3:0]  a_addr = '0;
   logic        a_wr = 0, a_rd = 0;
   logic [7:0]  a_wd = '0, a_rdata;
   logic        a_pgwr = 0;
   logic [1:0]  a_pgch = '0, a_xch = '0;
   logic [7:0]  a_pgd = '0;
   logic        a_stb = 0;
   logic [23:0] a_xaddr;
   logic [1:0]  a_dir;
   logic [3:0]  a_msk;

   dmarf_regfile #(.NUM_CH(4), .WORD_MODE(0), .PAGE_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(a_addr), .io_wr(a_wr), .io_rd(a_rd),
      .io_wdata(a_wd), .io_rdata(a_rdata), .pg_wr(a_pgwr), .pg_ch(a_pgch),
      .pg_wdata(a_pgd), .xfer_stb(a_stb), .xfer_ch(a_xch), .xfer_addr(a_xaddr),
      .xfer_dir(a_dir), .ch_masked(a_msk));

   // word-mode instance
   logic [4:0]  w_addr = '0;
   logic        w_wr = 0, w_rd = 0;
   logic [7:0]  w_wd = '0, w_rdata;
   logic        w_pgwr = 0;
   logic [1:0]  w_pgch = '0, w_xch = '0;
   logic [7:0]  w_pgd = '0;
   logic        w_stb = 0;
   logic [23:0] w_xaddr;
   logic [1:0]  w_dir;
   logic [1:0]  w_msk;

   dmarf_regfile #(.NUM_CH(2), .WORD_MODE(1), .PAGE_W(8)) dut_w (
      .clk(clk), .rst_n(rst_n), .io_addr(w_addr), .io_wr(w_wr), .io_rd(w_rd),
      .io_wdata(w_wd), .io_rdata(w_rdata), .pg_wr(w_pgwr), .pg_ch(w_pgch),
      .pg_wdata(w_pgd), .xfer_stb(w_stb), .xfer_ch(w_xch), .xfer_addr(w_xaddr),
      .xfer_dir(w_dir), .ch_masked(w_msk));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [7:0] d);
      @(negedge clk); a_addr = 4'(idx); a_wd = d; a_wr = 1;
      @(negedge clk); a_wr = 0;
   endtask

   task automatic rd(input int idx, output logic [7:0] d);
      @(negedge clk); a_addr = 4'(idx); a_rd = 1; #1 d = a_rdata;
      @(negedge clk); a_rd = 0;
   endtask

   task automatic page(input int ch, input logic [7:0] d);
      @(negedge clk); a_pgch = 2'(ch); a_pgd = d; a_pgwr = 1;
      @(negedge clk); a_pgwr = 0;
   endtask

   task automatic strobe(input int ch);
      @(negedge clk); a_xch = 2'(ch); a_stb = 1;
      @(negedge clk); a_stb = 0;
   endtask

   task automatic peek(input int ch, output logic [23:0] x, output logic [1:0] dr);
      @(negedge clk); a_xch = 2'(ch); #1 x = a_xaddr; dr = a_dir;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 masks after reset", 32'(a_msk), 32'hF);
      rd(8, d);  check("R1 status after reset", 32'(d), 32'h0);
      rd(0, d);  check("R1 addr low after reset", 32'(d), 32'h0);
      wr(12, 8'h00);
   endtask

   task automatic t_program();
      logic [7:0] d;
      wr(12, 8'h00);
      wr(0, 8'h34); wr(0, 8'h12);
      wr(1, 8'h02); wr(1, 8'h00);
      page(0, 8'h5A);
      wr(12, 8'h00);
      rd(0, d); check("R2 R4 addr low byte first", 32'(d), 32'h34);
      rd(0, d); check("R2 R4 addr high byte second", 32'(d), 32'h12);
      rd(1, d); check("R2 count low", 32'(d), 32'h02);
      rd(1, d); check("R2 count high", 32'(d), 32'h00);
   endtask

   task automatic t_ptr_clear();
      logic [7:0] d;
      wr(0, 8'h99);            // pointer now on high byte
      wr(12, 8'hFF);           // R3: clear with arbitrary data
      wr(0, 8'h34); wr(0, 8'h12);
      wr(12, 8'h00);
      rd(0, d); check("R3 clear sends next access low", 32'(d), 32'h34);
      rd(0, d); check("R3 high byte intact", 32'(d), 32'h12);
   endtask

   task automatic t_mode_and_mask();
      logic [7:0] d; logic [23:0] x; logic [1:0] dr;
      wr(11, 8'h48);           // single, read-from-memory, ch0
      peek(0, x, dr);
      check("R6 direction field", 32'(dr), 32'h2);
      strobe(0);               // masked: ignored
      wr(12, 8'h00);
      rd(1, d); check("R7 masked strobe ignored", 32'(d), 32'h02);
      wr(10, 8'h00);
      check("R5 unmask ch0", 32'(a_msk), 32'hE);
   endtask

   task automatic t_count_and_tc();
      logic [7:0] d; logic [23:0] x; logic [1:0] dr;
      strobe(0);
      peek(0, x, dr);
      check("R11 R7 address with page", 32'(x), 32'h5A1235);
      wr(12, 8'h00);
      rd(1, d); check("R7 count decremented", 32'(d), 32'h01);
      strobe(0);
      wr(12, 8'h00);
      rd(1, d); check("R4 live resample low", 32'(d), 32'h00);
      rd(1, d); check("R4 live resample high", 32'(d), 32'h00);
      strobe(0);               // count 0 -> terminal count
      check("R8 mask set at tc", 32'(a_msk[0]), 32'h1);
      wr(12, 8'h00);
      rd(1, d); check("R8 count low after tc", 32'(d), 32'hFF);
      rd(1, d); check("R8 count high after tc", 32'(d), 32'hFF);
      rd(0, d); check("R7 address after three steps", 32'(d), 32'h37);
      rd(8, d); check("R10 tc flag ch0", 32'(d), 32'h01);
      rd(8, d); check("R10 cleared by read", 32'(d), 32'h00);
   endtask

   task automatic t_autoinit();
      logic [7:0] d;
      wr(11, 8'h55);           // single, autoinit, write-to-memory, ch1
      wr(12, 8'h00);
      wr(2, 8'h10); wr(2, 8'h00);
      wr(3, 8'h01); wr(3, 8'h00);
      wr(10, 8'h01);
      strobe(1); strobe(1);
      check("R9 stays unmasked", 32'(a_msk[1]), 32'h0);
      wr(12, 8'h00);
      rd(2, d); check("R9 address reloaded", 32'(d), 32'h10);
      rd(2, d);
      rd(3, d); check("R9 count reloaded", 32'(d), 32'h01);
      rd(8, d); check("R10 tc flag ch1", 32'(d), 32'h02);
      wr(10, 8'h05);
      check("R5 mask ch1 via bit 2", 32'(a_msk[1]), 32'h1);
   endtask

   task automatic t_cascade();
      logic [7:0] d;
      wr(11, 8'hC2);
      wr(12, 8'h00);
      wr(4, 8'h40); wr(4, 8'h00);
      wr(10, 8'h02);
      strobe(2);
      wr(12, 8'h00);
      rd(4, d); check("R7 cascade strobe ignored", 32'(d), 32'h40);
   endtask

   task automatic t_wrap();
      logic [23:0] x; logic [1:0] dr;
      wr(11, 8'h47);
      wr(12, 8'h00);
      wr(6, 8'hFF); wr(6, 8'hFF);
      wr(7, 8'h05); wr(7, 8'h00);
      page(3, 8'h12);
      wr(10, 8'h03);
      peek(3, x, dr); check("R11 address before wrap", 32'(x), 32'h12FFFF);
      check("R6 direction ch3", 32'(dr), 32'h1);
      strobe(3);
      peek(3, x, dr); check("R11 wrap keeps page", 32'(x), 32'h120000);
   endtask

   task automatic wwr(input int port, input logic [7:0] d);
      @(negedge clk); w_addr = 5'(port); w_wd = d; w_wr = 1;
      @(negedge clk); w_wr = 0;
   endtask

   task automatic t_word();
      logic [7:0] d;
      wwr(24, 8'h00);
      wwr(0, 8'h00); wwr(0, 8'h80);
      wwr(2, 8'h04); wwr(2, 8'h00);
      @(negedge clk); w_pgch = 0; w_pgd = 8'h03; w_pgwr = 1;
      @(negedge clk); w_pgwr = 0; w_xch = 0; #1;
      check("R12 word address shift", 32'(w_xaddr), 32'h030000);
      wwr(22, 8'h44); wwr(20, 8'h00);
      check("R12 unmask via even port", 32'(w_msk), 32'h2);
      @(negedge clk); w_stb = 1;
      @(negedge clk); w_stb = 0; #1;
      check("R12 word step", 32'(w_xaddr), 32'h030002);
      wwr(24, 8'h00);
      wwr(1, 8'h77);           // odd port: ignored, no pointer toggle
      @(negedge clk); w_addr = 0; w_rd = 1; #1 d = w_rdata;
      @(negedge clk); w_rd = 0;
      check("R12 odd port ignored", 32'(d), 32'h01);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      t_reset();
      t_program();
      t_ptr_clear();
      t_mode_and_mask();
      t_count_and_tc();
      t_autoinit();
      t_cascade();
      t_wrap();
      t_word();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule